// File: doc/BRIEF.md
# Dual-Core Interrupt Aggregation Controller

This block gathers up to 32 level-sensitive board interrupt lines into one read-only status word. It steers them to four outputs: a normal interrupt line and a machine-check line for each of two processor cores. Every output has its own 32-bit enable mask. The masks are written and read over a simple register bus that has an address, a write strobe, a read strobe and 32-bit data. The status word shows each live source after a two-flop synchronizer. It does not latch, so a bit clears when its source drops.

Each output is registered. Its value is the OR of the synchronized status ANDed with that output's mask. The outputs are not arbitrated against each other, so one source that is enabled in several masks drives all of those outputs together. Software clears or sets a core's masks to steer the sources. All masks reset to zero, which leaves machine checks disabled until software enables them on purpose.

Top module: `irq_aggr_top`

## Requirements
- R1: A read at offset 0x00 returns the synchronized source levels. Bit 6 and bits 17 to 31 always read as zero, and a source on those positions never asserts any output, even when its mask bit is set.
- R2: A status bit follows its source two clocks after the source changes and is not latched. When the source falls, the bit and any output that depends on it fall again.
- R3: Writes to offset 0x00 have no effect on the status readback or on the outputs.
- R4: `irq_o[n]` is the registered OR over all bits of (status AND the interrupt mask of core n). The interrupt masks are at offsets 0x10 (core 0) and 0x14 (core 1), and a mask bit of 1 enables its source.
- R5: `mcp_o[n]` is the registered OR over all bits of (status AND the machine-check mask of core n). The machine-check masks are at offsets 0x18 (core 0) and 0x1C (core 1).
- R6: One source that is enabled in several masks asserts every matching output in the same cycle.
- R7: Out of reset, all four masks read as zero, all outputs are low, and the read data is zero.
- R8: Every mask reads back the last value written to it. Read data appears on `reg_rdata_o` in the cycle after `reg_rd_i` is sampled high, and is zero after any cycle with `reg_rd_i` low.
- R9: Reads of any offset other than 0x00, 0x10, 0x14, 0x18 and 0x1C return zero, and writes to them change no mask and no output.
- R10: After a mask write is sampled on a clock edge, the affected output changes on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_src_i | input | 32 | Level interrupt sources, asynchronous to clk_i |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 2 | Per-core interrupt outputs |
| mcp_o | output | 2 | Per-core machine-check outputs |

## Verification
A corrupted mask register shows up in two places: on the output it gates, one clock after the status becomes non-zero, and on the next readback of that offset. The bench compares every output and the read data against a behavioural model on every clock, so such an error is caught within a cycle of becoming visible. A stuck or extra synchronizer stage shifts output edges by a cycle, and a leaked reserved bit turns up in the status readback. Both are therefore caught at the first transition of a source.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;
  localparam logic [7:0] OFS_STATUS   = 8'h00;
  localparam logic [7:0] OFS_IRQ_BASE = 8'h10;
  localparam logic [7:0] OFS_MCP_BASE = 8'h18;
  localparam int unsigned CORE_STRIDE = 4;

  function automatic logic [7:0] core_ofs(logic [7:0] base, int unsigned core);
    return base + 8'(CORE_STRIDE * core);
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_aggr_pkg::*;
#(
  parameter int unsigned NUM_CORES = 2,
  parameter int unsigned DW        = 32,
  parameter int unsigned AW        = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [AW-1:0]                 addr_i,
  input  logic                          wr_i,
  input  logic                          rd_i,
  input  logic [DW-1:0]                 wdata_i,
  input  logic [DW-1:0]                 status_i,
  output logic [DW-1:0]                 rdata_o,
  output logic [NUM_CORES-1:0][DW-1:0]  irq_mask_o,
  output logic [NUM_CORES-1:0][DW-1:0]  mcp_mask_o
);
  logic [NUM_CORES-1:0] hit_irq, hit_mcp;
  logic                 hit_status;
  logic [DW-1:0]        rd_val;
  logic [DW-1:0]        rdata_q;

  assign hit_status = (addr_i == AW'(OFS_STATUS));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    localparam logic [AW-1:0] IRQ_OFS = AW'(core_ofs(OFS_IRQ_BASE, c));
    localparam logic [AW-1:0] MCP_OFS = AW'(core_ofs(OFS_MCP_BASE, c));

    assign hit_irq[c] = (addr_i == IRQ_OFS);
    assign hit_mcp[c] = (addr_i == MCP_OFS);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        irq_mask_o[c] <= '0;
        mcp_mask_o[c] <= '0;
      end else if (wr_i) begin
        if (hit_irq[c]) irq_mask_o[c] <= wdata_i;
        if (hit_mcp[c]) mcp_mask_o[c] <= wdata_i;
      end
    end
  end

  // unmapped offsets fall through to zero
  always_comb begin
    rd_val = '0;
    if (hit_status) rd_val = status_i;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (hit_irq[c]) rd_val = irq_mask_o[c];
      if (hit_mcp[c]) rd_val = mcp_mask_o[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_val;
    else           rdata_q <= '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_route.sv
module irq_route #(
  parameter int unsigned NUM_CORES = 2,
  parameter int unsigned DW        = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [DW-1:0]                status_i,
  input  logic [NUM_CORES-1:0][DW-1:0] irq_mask_i,
  input  logic [NUM_CORES-1:0][DW-1:0] mcp_mask_i,
  output logic [NUM_CORES-1:0]         irq_o,
  output logic [NUM_CORES-1:0]         mcp_o
);
  // no exclusivity between outputs: each one reduces independently
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_out
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        irq_o[c] <= 1'b0;
        mcp_o[c] <= 1'b0;
      end else begin
        irq_o[c] <= |(status_i & irq_mask_i[c]);
        mcp_o[c] <= |(status_i & mcp_mask_i[c]);
      end
    end
  end
endmodule

// File: rtl/irq_aggr_top.sv
module irq_aggr_top #(
  parameter int unsigned NUM_SRC     = 32,
  parameter int unsigned NUM_CORES   = 2,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [NUM_SRC-1:0] SRC_VALID = NUM_SRC'(32'h0001_FFBF)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SRC-1:0]   irq_src_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic                 reg_wr_i,
  input  logic                 reg_rd_i,
  input  logic [NUM_SRC-1:0]   reg_wdata_i,
  output logic [NUM_SRC-1:0]   reg_rdata_o,
  output logic [NUM_CORES-1:0] irq_o,
  output logic [NUM_CORES-1:0] mcp_o
);
  logic [NUM_SRC-1:0]                sync_src;
  logic [NUM_SRC-1:0]                status;
  logic [NUM_CORES-1:0][NUM_SRC-1:0] irq_mask;
  logic [NUM_CORES-1:0][NUM_SRC-1:0] mcp_mask;

  irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (irq_src_i),
    .sync_o  (sync_src)
  );

  // reserved positions forced low
  assign status = sync_src & SRC_VALID;

  irq_regfile #(.NUM_CORES(NUM_CORES), .DW(NUM_SRC), .AW(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (reg_addr_i),
    .wr_i       (reg_wr_i),
    .rd_i       (reg_rd_i),
    .wdata_i    (reg_wdata_i),
    .status_i   (status),
    .rdata_o    (reg_rdata_o),
    .irq_mask_o (irq_mask),
    .mcp_mask_o (mcp_mask)
  );

  irq_route #(.NUM_CORES(NUM_CORES), .DW(NUM_SRC)) u_route (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .status_i   (status),
    .irq_mask_i (irq_mask),
    .mcp_mask_i (mcp_mask),
    .irq_o      (irq_o),
    .mcp_o      (mcp_o)
  );
endmodule

// File: rtl/irq_aggr_checker.sv
module irq_aggr_checker
  import irq_aggr_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 32,
  parameter int unsigned NUM_CORES = 2,
  parameter int unsigned AW        = 8,
  parameter logic [NUM_SRC-1:0] SRC_VALID = NUM_SRC'(32'h0001_FFBF)
) (
  input logic                                clk_i,
  input logic                                rst_ni,
  input logic [AW-1:0]                       reg_addr_i,
  input logic                                reg_rd_i,
  input logic [NUM_SRC-1:0]                  reg_rdata_o,
  input logic [NUM_CORES-1:0]                irq_o,
  input logic [NUM_CORES-1:0]                mcp_o,
  input logic [NUM_CORES-1:0][NUM_SRC-1:0]   irq_mask,
  input logic [NUM_CORES-1:0][NUM_SRC-1:0]   mcp_mask
);
  logic mapped;
  always_comb begin
    mapped = (reg_addr_i == AW'(OFS_STATUS));
    for (int c = 0; c < NUM_CORES; c++) begin
      if (reg_addr_i == AW'(core_ofs(OFS_IRQ_BASE, c))) mapped = 1'b1;
      if (reg_addr_i == AW'(core_ofs(OFS_MCP_BASE, c))) mapped = 1'b1;
    end
  end

  assert_status_rsvd_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == AW'(OFS_STATUS)) |=> ((reg_rdata_o & ~SRC_VALID) == '0));

  assert_rdata_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rd_i |=> (reg_rdata_o == '0));

  assert_unmapped_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && !mapped) |=> (reg_rdata_o == '0));

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R7: assert (irq_o == '0 && mcp_o == '0 && reg_rdata_o == '0);
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assert_irq_masked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_mask[c] == '0) |=> !irq_o[c]);
    assert_mcp_masked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mcp_mask[c] == '0) |=> !mcp_o[c]);
  end
endmodule

bind irq_aggr_top irq_aggr_checker #(
  .NUM_SRC(NUM_SRC), .NUM_CORES(NUM_CORES), .AW(ADDR_W), .SRC_VALID(SRC_VALID)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .mcp_o       (mcp_o),
  .irq_mask    (irq_mask),
  .mcp_mask    (mcp_mask)
);

// File: tb/irq_aggr_top_test.sv
module irq_aggr_top_test;
  localparam logic [31:0] VALID = 32'h0001_FFBF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq, mcp;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_aggr_top uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_src_i(src), .reg_addr_i(addr),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .mcp_o(mcp)
  );

  // behavioural reference
  logic [31:0] m_pipe[$];
  logic [31:0] m_status, m_rdata;
  logic [31:0] m_irqm[2], m_mcpm[2];
  logic [1:0]  m_irq, m_mcp;

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h00: return m_status;
      8'h10: return m_irqm[0];
      8'h14: return m_irqm[1];
      8'h18: return m_mcpm[0];
      8'h1C: return m_mcpm[1];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pipe = {32'h0};
      m_status = '0; m_rdata = '0; m_irq = '0; m_mcp = '0;
      for (int c = 0; c < 2; c++) begin m_irqm[c] = '0; m_mcpm[c] = '0; end
    end else begin
      for (int c = 0; c < 2; c++) begin
        m_irq[c] = |(m_status & m_irqm[c]);
        m_mcp[c] = |(m_status & m_mcpm[c]);
      end
      m_rdata = rd ? m_read(addr) : 32'h0;
      if (wr) begin
        case (addr)
          8'h10: m_irqm[0] = wdata;
          8'h14: m_irqm[1] = wdata;
          8'h18: m_mcpm[0] = wdata;
          8'h1C: m_mcpm[1] = wdata;
          default: ;
        endcase
      end
      m_status = m_pipe.pop_front() & VALID;
      m_pipe.push_back(src);
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 irq_o vs model", {30'h0, irq}, {30'h0, m_irq});
      chk("R5 mcp_o vs model", {30'h0, mcp}, {30'h0, m_mcp});
      chk("R8 rdata vs model", rdata, m_rdata);
    end
  end

  task automatic reg_wr(logic [7:0] a, logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_rd(logic [7:0] a, logic [31:0] exp, string tag);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk(tag, rdata, exp);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    idle(3);
    chk("R7 reset irq_o", {30'h0, irq}, 32'h0);
    chk("R7 reset mcp_o", {30'h0, mcp}, 32'h0);
    rst_n = 1'b1;
    idle(1);
    chk("R7 rdata after reset", rdata, 32'h0);
    reg_rd(8'h10, 32'h0, "R7 irq mask0 reset");
    reg_rd(8'h14, 32'h0, "R7 irq mask1 reset");
    reg_rd(8'h18, 32'h0, "R7 mcp mask0 reset");
    reg_rd(8'h1C, 32'h0, "R7 mcp mask1 reset");

    src = 32'hFFFF_FFFF;
    idle(3);
    reg_rd(8'h00, 32'h0001_FFBF, "R1 status reserved bits zero");

    src = 32'h0000_0005;
    idle(1);
    reg_rd(8'h00, 32'h0001_FFBF, "R2 status not yet changed after one clock");
    reg_rd(8'h00, 32'h0000_0005, "R2 status follows after two clocks");

    reg_wr(8'h00, 32'hFFFF_FFFF);
    reg_rd(8'h00, 32'h0000_0005, "R3 status write ignored");
    chk("R3 outputs unaffected", {28'h0, irq, mcp}, 32'h0);

    reg_wr(8'h10, 32'h0000_0001);
    chk("R10 irq_o not yet set in write cycle", {31'h0, irq[0]}, 32'h0);
    idle(1);
    chk("R10 R4 irq_o[0] one clock after write", {30'h0, irq}, 32'h1);

    reg_wr(8'h1C, 32'h0000_0004);
    idle(1);
    chk("R5 mcp_o[1] asserted", {30'h0, mcp}, 32'h2);
    reg_rd(8'h1C, 32'h0000_0004, "R8 mcp mask1 readback");

    reg_wr(8'h14, 32'h0000_0001);
    reg_wr(8'h18, 32'h0000_0005);
    idle(1);
    chk("R6 both irq lines", {30'h0, irq}, 32'h3);
    chk("R6 both mcp lines", {30'h0, mcp}, 32'h3);

    reg_wr(8'h20, 32'h0);
    reg_wr(8'h11, 32'h0);
    idle(1);
    reg_rd(8'h20, 32'h0, "R9 unmapped read 0x20");
    reg_rd(8'h11, 32'h0, "R9 unmapped read 0x11");
    reg_rd(8'h10, 32'h1, "R9 irq mask0 untouched");
    chk("R9 outputs unchanged", {28'h0, irq, mcp}, 32'hF);

    src = 32'h0;
    idle(4);
    chk("R2 outputs fall with source", {28'h0, irq, mcp}, 32'h0);

    reg_wr(8'h10, 32'hFFFF_FFFF);
    src = 32'h8002_0040;
    idle(4);
    chk("R1 reserved source never routed", {30'h0, irq}, 32'h0);
    reg_rd(8'h00, 32'h0, "R1 reserved source status zero");

    for (int i = 0; i < 400; i++) begin
      logic [2:0] sel;
      sel = 3'($urandom_range(0, 6));
      src = $urandom & 32'h0001_FFFF;
      wr = ($urandom_range(0, 3) == 0);
      rd = ($urandom_range(0, 1) == 0);
      wdata = (1 << $urandom_range(0, 16)) | (1 << $urandom_range(0, 16));
      case (sel)
        3'd0: addr = 8'h00;
        3'd1: addr = 8'h10;
        3'd2: addr = 8'h14;
        3'd3: addr = 8'h18;
        3'd4: addr = 8'h1C;
        3'd5: addr = 8'h24;
        default: addr = 8'h0C;
      endcase
      @(negedge clk);
    end
    wr = 1'b0; rd = 1'b0;
    idle(4);
    finish_run();
  end
endmodule